// File: doc/BRIEF.md
# Event-Code Mapped Trigger Generator

This block sits behind a timing-link receiver. Every cycle of the event clock it takes one 8-bit event code and drives a bank of hardware trigger outputs. A 256-entry lookup table, indexed by the code, holds a bit mask of the trigger channels that the code fires. Code 0 is the idle symbol and never fires anything.

When a code hits an enabled channel, that channel captures its programmed delay and width. After the delay has run out it raises its output for the programmed number of clocks. Software fills the lookup table and the per-channel enable, delay and width registers through a write-only port. A two-bit field at the top of the address selects the register class.

Top module: `evt_trig_gen`

## Requirements
- R1: After reset `trig_o` is all low. Every lookup entry, enable bit, delay and width is zero, so no code fires any channel until software programs the block.
- R2: With `cfg_addr_i[9:8]=00`, a write stores `cfg_wdata_i[7:0]` as the channel mask for code `cfg_addr_i[7:0]`. Mask bit i selects channel i. A non-zero code fires exactly the enabled channels whose bits are set in its entry.
- R3: Code 0 fires no channel, whatever its lookup entry holds.
- R4: With `cfg_addr_i[9:8]=01`, `cfg_wdata_i[7:0]` is the enable mask, bit i for channel i. A disabled channel ignores hits. Clearing the bit does not cancel a delay or pulse that is already running.
- R5: With `cfg_addr_i[9:8]=10`, `cfg_wdata_i` sets the delay D of channel `cfg_addr_i[2:0]`. For a code sampled at clock edge k, the output rises at edge k+D. D=0 gives a rise at edge k.
- R6: With `cfg_addr_i[9:8]=11`, `cfg_wdata_i` sets the width W of channel `cfg_addr_i[2:0]`. The output stays high for exactly W clocks. W=0 gives no pulse.
- R7: A hit that arrives while a channel's delay is still counting restarts the delay from the hit, using the current delay and width.
- R8: A hit that arrives while a channel's output is high is ignored. The pulse keeps its length.
- R9: A lookup write applies to codes sampled from the next edge on. A code sampled at the same edge as the write uses the old entry. Rewriting an entry does not disturb a pulse that is already running.
- R10: Delay and width are captured at the hit. Rewriting either register while a channel waits or pulses does not change that firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Event clock, one code per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_code_i | input | 8 | Incoming event code, 0 = no event |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 10 | [9:8] register class, [7:0] code or channel index |
| cfg_wdata_i | input | 32 | Configuration write data |
| trig_o | output | 8 | Trigger outputs, one per channel |

## Verification
The hardest case to reach is a channel that receives a second hit from the port while it is already busy. The second hit must land either inside the delay window, where it restarts the countdown, or inside the pulse, where it is ignored. The stimulus programs known delays and widths and then places the repeated code a fixed number of cycles after the first one. A cycle-accurate model records the start and end cycles of each pending pulse, so both windows are checked exactly. The same-edge lookup write and the rewrites during a delay are produced by driving the write and the code in the same cycle.

// File: rtl/evt_trig_pkg.sv
package evt_trig_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_DLY  = 2'd1,
    CH_PLS  = 2'd2
  } ch_state_e;

  typedef enum logic [1:0] {
    SEL_MAP = 2'b00,
    SEL_EN  = 2'b01,
    SEL_DLY = 2'b10,
    SEL_WID = 2'b11
  } cfg_sel_e;
endpackage

// File: rtl/evt_map_mem.sv
module evt_map_mem #(
  parameter int CODE_W = 8,
  parameter int N_CH   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] waddr_i,
  input  logic [N_CH-1:0]   wdata_i,
  input  logic [CODE_W-1:0] raddr_i,
  output logic [N_CH-1:0]   rdata_o
);
  localparam int DEPTH = 1 << CODE_W;

  logic [N_CH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read sees pre-write contents at the same edge
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/evt_trig_chan.sv
module evt_trig_chan
  import evt_trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic             trig_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ch_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
      wid_q <= '0;
    end else if (hit_i && st_q != CH_PLS) begin
      wid_q <= wid_i;
      if (dly_i == '0) begin
        if (wid_i != '0) begin
          st_q  <= CH_PLS;
          cnt_q <= wid_i;
        end else begin
          st_q  <= CH_IDLE;
          cnt_q <= '0;
        end
      end else begin
        st_q  <= CH_DLY;
        cnt_q <= dly_i;
      end
    end else begin
      unique case (st_q)
        CH_DLY: begin
          if (cnt_q == ONE) begin
            if (wid_q != '0) begin
              st_q  <= CH_PLS;
              cnt_q <= wid_q;
            end else begin
              st_q  <= CH_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        CH_PLS: begin
          if (cnt_q == ONE) st_q <= CH_IDLE;
          else              cnt_q <= cnt_q - ONE;
        end
        default: ;
      endcase
    end
  end

  assign trig_o = (st_q == CH_PLS);
  assign busy_o = (st_q != CH_IDLE);
endmodule

// File: rtl/evt_trig_gen.sv
module evt_trig_gen
  import evt_trig_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int N_CH   = 8,
  parameter int CNT_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W-1:0]   evt_code_i,
  input  logic                cfg_we_i,
  input  logic [CODE_W+1:0]   cfg_addr_i,
  input  logic [CNT_W-1:0]    cfg_wdata_i,
  output logic [N_CH-1:0]     trig_o
);
  localparam int ADDR_W   = CODE_W + 2;
  localparam int CH_SEL_W = $clog2(N_CH);

  cfg_sel_e                     sel_w;
  logic [CH_SEL_W-1:0]          ch_sel_w;
  logic [N_CH-1:0]              map_rd_w;
  logic [N_CH-1:0]              hit_w;
  logic [N_CH-1:0]              busy_w;
  logic [N_CH-1:0]              en_q;
  logic [N_CH-1:0][CNT_W-1:0]   dly_q;
  logic [N_CH-1:0][CNT_W-1:0]   wid_q;

  assign sel_w    = cfg_sel_e'(cfg_addr_i[ADDR_W-1 -: 2]);
  assign ch_sel_w = cfg_addr_i[CH_SEL_W-1:0];

  evt_map_mem #(
    .CODE_W (CODE_W),
    .N_CH   (N_CH)
  ) i_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && sel_w == SEL_MAP),
    .waddr_i (cfg_addr_i[CODE_W-1:0]),
    .wdata_i (cfg_wdata_i[N_CH-1:0]),
    .raddr_i (evt_code_i),
    .rdata_o (map_rd_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      dly_q <= '0;
      wid_q <= '0;
    end else if (cfg_we_i) begin
      unique case (sel_w)
        SEL_EN:  en_q            <= cfg_wdata_i[N_CH-1:0];
        SEL_DLY: dly_q[ch_sel_w] <= cfg_wdata_i;
        SEL_WID: wid_q[ch_sel_w] <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  assign hit_w = (evt_code_i != '0) ? (map_rd_w & en_q) : '0;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    evt_trig_chan #(
      .CNT_W (CNT_W)
    ) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit_w[g]),
      .dly_i  (dly_q[g]),
      .wid_i  (wid_q[g]),
      .trig_o (trig_o[g]),
      .busy_o (busy_w[g])
    );
  end
endmodule

// File: rtl/evt_trig_chk.sv
module evt_trig_chk #(
  parameter int CODE_W = 8,
  parameter int N_CH   = 8,
  parameter int CNT_W  = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [CODE_W-1:0]         evt_code_i,
  input logic [N_CH-1:0]           trig_o,
  input logic [N_CH-1:0]           hit_w,
  input logic [N_CH-1:0]           busy_w,
  input logic [N_CH-1:0]           en_q,
  input logic [N_CH-1:0][CNT_W-1:0] dly_q,
  input logic [N_CH-1:0][CNT_W-1:0] wid_q
);
  // R3
  idle_code_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_code_i == '0 && busy_w == '0) |=> (busy_w == '0 && trig_o == '0));

  // R4
  all_disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0 && busy_w == '0) |=> (busy_w == '0 && trig_o == '0));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    // R5
    zero_delay_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_w[g] && !trig_o[g] && dly_q[g] == '0 && wid_q[g] != '0) |=> trig_o[g]);

    // R5
    delay_holds_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_w[g] && !trig_o[g] && dly_q[g] != '0) |=> !trig_o[g]);

    // R7
    retrigger_rearms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_w[g] && busy_w[g] && !trig_o[g] && dly_q[g] > CNT_W'(1)) |=> (busy_w[g] && !trig_o[g]));
  end
endmodule

bind evt_trig_gen evt_trig_chk #(
  .CODE_W (CODE_W),
  .N_CH   (N_CH),
  .CNT_W  (CNT_W)
) i_evt_trig_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_code_i (evt_code_i),
  .trig_o     (trig_o),
  .hit_w      (hit_w),
  .busy_w     (busy_w),
  .en_q       (en_q),
  .dly_q      (dly_q),
  .wid_q      (wid_q)
);

// File: tb/test_evt_trig_gen.sv
`timescale 1ns/1ps
module test_evt_trig_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code = '0;
  logic       we = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0] trig;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  evt_trig_gen i_evt_trig_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .evt_code_i  (code),
    .cfg_we_i    (we),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .trig_o      (trig)
  );

  // reference model: each channel keeps the cycle window of its pending pulse
  logic [7:0] m_map [256];
  bit         m_en  [8];
  longint     m_dly [8], m_wid [8], m_st [8], m_end [8];
  longint     cyc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_map[i] = '0;
      for (int c = 0; c < 8; c++) begin
        m_en[c] = 0; m_dly[c] = 0; m_wid[c] = 0; m_st[c] = 0; m_end[c] = 0;
      end
      cyc = 0;
    end else begin
      longint k;
      k = cyc + 1;
      for (int c = 0; c < 8; c++) begin
        bit pulsing;
        pulsing = (m_st[c] <= cyc) && (cyc < m_end[c]);
        if (code != 0 && m_map[code][c] && m_en[c] && !pulsing) begin
          m_st[c]  = k + m_dly[c];
          m_end[c] = m_st[c] + m_wid[c];
        end
      end
      if (we) begin
        case (addr[9:8])
          2'b00: m_map[addr[7:0]] = wdata[7:0];
          2'b01: for (int c = 0; c < 8; c++) m_en[c] = wdata[c];
          2'b10: m_dly[addr[2:0]] = wdata;
          default: m_wid[addr[2:0]] = wdata;
        endcase
      end
      cyc = k;
    end
  end

  function automatic logic [7:0] expected();
    logic [7:0] e;
    for (int c = 0; c < 8; c++) e[c] = (m_st[c] <= cyc) && (cyc < m_end[c]);
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (trig !== expected()) begin
        n_fail++;
        $display("FAIL %s cycle %0d: trig_o actual=%b expected=%b", cur_req, cyc, trig, expected());
      end
    end
  end

  task automatic step(input logic [7:0] c, input logic w, input logic [1:0] sel,
                      input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    code = c; we = w; addr = {sel, idx}; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'd0, 1'b0, 2'b00, 8'd0, 32'd0);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] idx, input logic [31:0] d);
    step(8'd0, 1'b1, sel, idx, d);
  endtask

  task automatic hit(input logic [7:0] c);
    step(c, 1'b0, 2'b00, 8'd0, 32'd0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 explicit reset check
    n_chk++;
    if (trig !== 8'h00) begin
      n_fail++;
      $display("FAIL R1 reset: trig_o actual=%b expected=%b", trig, 8'h00);
    end
    cur_req = "R1";
    wr(2'b01, 8'd0, 32'hFF);
    hit(8'd1); hit(8'h80); hit(8'hFF); idle(5);

    cur_req = "R2";
    wr(2'b00, 8'd5, 32'h05);
    wr(2'b10, 8'd0, 32'd3); wr(2'b11, 8'd0, 32'd2);
    wr(2'b10, 8'd2, 32'd0); wr(2'b11, 8'd2, 32'd4);
    wr(2'b00, 8'd6, 32'h02);
    wr(2'b10, 8'd1, 32'd2); wr(2'b11, 8'd1, 32'd3);
    hit(8'd5); idle(10);
    hit(8'd6); hit(8'd5); idle(10);

    cur_req = "R3";
    wr(2'b00, 8'd0, 32'hFF);
    hit(8'd0); hit(8'd0); idle(8);

    cur_req = "R4";
    wr(2'b01, 8'd0, 32'hFE);
    hit(8'd5); idle(8);
    wr(2'b01, 8'd0, 32'hFF);
    wr(2'b10, 8'd0, 32'd6);
    hit(8'd5); idle(1);
    wr(2'b01, 8'd0, 32'h00);
    idle(10);
    wr(2'b01, 8'd0, 32'hFF);

    cur_req = "R5";
    wr(2'b00, 8'd9, 32'h08);
    wr(2'b10, 8'd3, 32'd20); wr(2'b11, 8'd3, 32'd1);
    hit(8'd9); idle(25);

    cur_req = "R6";
    wr(2'b11, 8'd3, 32'd0);
    hit(8'd9); idle(25);
    wr(2'b10, 8'd3, 32'd0); wr(2'b11, 8'd3, 32'd5);
    hit(8'd9); idle(8);

    cur_req = "R7";
    wr(2'b00, 8'd10, 32'h10);
    wr(2'b10, 8'd4, 32'd8); wr(2'b11, 8'd4, 32'd2);
    hit(8'd10); idle(3); hit(8'd10); idle(14);

    cur_req = "R8";
    wr(2'b00, 8'd11, 32'h20);
    wr(2'b10, 8'd5, 32'd0); wr(2'b11, 8'd5, 32'd6);
    hit(8'd11); idle(2); hit(8'd11); idle(6); hit(8'd11); idle(8);

    cur_req = "R9";
    wr(2'b10, 8'd6, 32'd0); wr(2'b11, 8'd6, 32'd4);
    step(8'd12, 1'b1, 2'b00, 8'd12, 32'h40);
    idle(4);
    hit(8'd12);
    wr(2'b00, 8'd12, 32'h00);
    idle(6);
    hit(8'd12); idle(4);

    cur_req = "R10";
    wr(2'b00, 8'd13, 32'h80);
    wr(2'b10, 8'd7, 32'd10); wr(2'b11, 8'd7, 32'd3);
    hit(8'd13); idle(2);
    wr(2'b10, 8'd7, 32'd1); wr(2'b11, 8'd7, 32'd9);
    idle(16);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule